// File: doc/BRIEF.md
# Receive Frame Address Filter and Status Builder

This block takes one descriptor per received Ethernet frame, presented together with a one-cycle end-of-frame strobe, and decides whether the frame is kept. The descriptor holds the destination address, the byte length, and the CRC, alignment and invalid-symbol flags. The block compares the destination against a 48-bit station address and a 64-entry multicast hash table. Six accept controls and one length-threshold selector then decide the outcome.

One cycle after the strobe, the block presents an accept decision and a 16-bit status word for one cycle. Receive logic upstream supplies the error flags. The status word is written into the frame header in the receive buffer.

Top module: `rx_addr_filter`

## Requirements
- R1: `res_valid` is high for exactly the one cycle that follows a cycle with `frame_end` high. While `res_valid` is low, `res_accept` and `res_status` are all zeros. After reset all three outputs are zero.
- R2: An all-ones destination sets status bit 13 and leaves bit 15 clear. Such a frame passes the address stage only when `acc_bcast` is 1.
- R3: A destination whose group bit (`dst_addr[40]`, least significant bit of the first byte on the wire) is 1 and which is not all ones sets status bit 15. It passes the address stage only when `acc_mcast` is 1 and `mc_table[h]` is 1. The index h is bits 31..26 of a CRC-32 over the 6 address bytes. The CRC uses polynomial 04C11DB7h, starts from all ones, has no final inversion, feeds `dst_addr[47:40]` first, and feeds each byte least significant bit first.
- R4: Status bit 14 is set when the destination equals `station_addr`. Such a frame passes the address stage when `acc_phys` is 1.
- R5: With `acc_promisc` at 1, any destination whose group bit is 0 passes the address stage.
- R6: Status bit 4 is set when the length is below 64. A runt without errors is accepted only if `acc_runt` is 1 and the length is at least 8.
- R7: Status bit 3 is set when the length exceeds 4096. This condition alone never rejects a frame.
- R8: Status bits 2, 1 and 5 report the CRC, alignment and symbol flags. A frame with any of these flags is accepted when `acc_err` is 1, subject to the runt rule of R6.
- R9: When both `acc_err` and `acc_runt` are 0, an error frame is accepted when its length exceeds 64 (`err_short` = 0) or exceeds 8 (`err_short` = 1). When `acc_runt` is 1 and `acc_err` is 0, every error frame is rejected.
- R10: Status bit 0 is set only for an accepted frame that has no error, runt or long condition. Bits 12..6 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | Descriptor strobe, one cycle per frame |
| dst_addr | input | 48 | Destination address; bits 47..40 are the first byte on the wire |
| frame_len | input | 14 | Frame length in bytes, header to CRC |
| crc_bad | input | 1 | CRC error flag |
| align_bad | input | 1 | Alignment error flag |
| sym_bad | input | 1 | Invalid symbol flag |
| station_addr | input | 48 | Own station address |
| mc_table | input | 64 | Multicast hash table |
| acc_err | input | 1 | Accept error frames |
| acc_runt | input | 1 | Accept runts of 8 bytes or more |
| acc_bcast | input | 1 | Accept broadcast |
| acc_mcast | input | 1 | Accept hashed multicast |
| acc_phys | input | 1 | Accept station-address frames |
| acc_promisc | input | 1 | Accept any individual address |
| err_short | input | 1 | Selects 8-byte instead of 64-byte error-frame length limit |
| res_valid | output | 1 | Result strobe |
| res_accept | output | 1 | Accept decision |
| res_status | output | 16 | Receive status word |

## Verification
The bench targets several length edges:
- 63/64 and 4096/4097, where an off-by-one flags a legal frame as runt or long.
- 7/8 under runt accept, where a wrong comparison drops the shortest allowed runt.
- 64/65 and 8/9 on the error-length fallback, where swapping the threshold keeps frames that must go.

Multicast is checked with single-bit and single-hole tables, so a wrong byte or bit order in the hash selects the wrong table entry. Broadcast traffic confirms that bit 15 stays clear. An error frame with a runt-only policy must be dropped, which catches a design that treats the two accept controls as interchangeable.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int LEN_W      = 14,
  parameter int HASH_W     = 6,
  parameter int MIN_LEN    = 64,
  parameter int RUNT_FLOOR = 8,
  parameter int MAX_LEN    = 4096
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_end,
  input  logic [47:0]            dst_addr,
  input  logic [LEN_W-1:0]       frame_len,
  input  logic                   crc_bad,
  input  logic                   align_bad,
  input  logic                   sym_bad,
  input  logic [47:0]            station_addr,
  input  logic [(1<<HASH_W)-1:0] mc_table,
  input  logic                   acc_err,
  input  logic                   acc_runt,
  input  logic                   acc_bcast,
  input  logic                   acc_mcast,
  input  logic                   acc_phys,
  input  logic                   acc_promisc,
  input  logic                   err_short,
  output logic                   res_valid,
  output logic                   res_accept,
  output logic [15:0]            res_status
);
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  function automatic logic [31:0] addr_crc(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ a[40-8*b+i];
        c  = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
      end
    return c;
  endfunction

  logic [31:0]       crc_v;
  logic [HASH_W-1:0] hidx;
  logic is_bc, is_mc, is_pm, is_runt, is_long, has_err;
  logic addr_ok, size_ok, qual_ok, acc_n;
  logic [15:0] st_n;

  assign crc_v   = addr_crc(dst_addr);
  assign hidx    = crc_v[31 -: HASH_W];
  assign is_bc   = &dst_addr;
  assign is_mc   = dst_addr[40] & ~is_bc;
  assign is_pm   = (dst_addr == station_addr);
  assign is_runt = (frame_len < LEN_W'(MIN_LEN));
  assign is_long = (frame_len > LEN_W'(MAX_LEN));
  assign has_err = crc_bad | align_bad | sym_bad;

  assign addr_ok = (is_bc & acc_bcast) | (is_mc & acc_mcast & mc_table[hidx])
                 | (is_pm & acc_phys) | (~dst_addr[40] & acc_promisc);
  assign size_ok = ~is_runt | (acc_runt & (frame_len >= LEN_W'(RUNT_FLOOR)));

  always_comb begin
    if (!has_err)     qual_ok = size_ok;
    else if (acc_err) qual_ok = size_ok;
    else              qual_ok = ~acc_runt &
                        (frame_len > (err_short ? LEN_W'(RUNT_FLOOR) : LEN_W'(MIN_LEN)));
  end

  assign acc_n = addr_ok & qual_ok;
  assign st_n  = {is_mc, is_pm, is_bc, 7'b0, sym_bad, is_runt, is_long,
                  crc_bad, align_bad, acc_n & ~has_err & ~is_runt & ~is_long};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_status <= '0;
    end else begin
      res_valid  <= frame_end;
      res_accept <= frame_end & acc_n;
      res_status <= frame_end ? st_n : 16'h0;
    end
  end
endmodule

module rx_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_end,
  input logic        res_valid,
  input logic        res_accept,
  input logic [15:0] res_status
);
  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(frame_end));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_status == 16'h0 && !res_accept));
  p_bc_mc_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_status[15] && res_status[13]));
  p_runt_long_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_status[4] && res_status[3]));
  p_ok_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[0] |-> (res_accept && res_status[5:1] == 5'b0));
  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[12:6] == 7'b0);
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
  .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status));

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  logic clk = 0, rst_n = 0, frame_end = 0;
  logic [47:0] dst_addr = 0, station_addr = 48'h0011_2233_4455;
  logic [13:0] frame_len = 0;
  logic crc_bad = 0, align_bad = 0, sym_bad = 0;
  logic [63:0] mc_table = '1;
  logic acc_err = 0, acc_runt = 0, acc_bcast = 1, acc_mcast = 1;
  logic acc_phys = 1, acc_promisc = 0, err_short = 0;
  logic res_valid, res_accept;
  logic [15:0] res_status;
  int checks = 0, bad = 0;
  bit e_v = 0, e_a = 0;
  logic [15:0] e_s = 0;

  always #10 clk = ~clk;

  rx_addr_filter uut (.*);

  function automatic int hash_of(input logic [47:0] a);
    int unsigned r = 32'hFFFF_FFFF;
    int idx = 0;
    for (int b = 0; b < 6; b++) begin
      r = r ^ int'((a >> (40 - 8*b)) & 48'hFF);
      for (int k = 0; k < 8; k++)
        r = (r & 1) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    end
    for (int i = 0; i < 6; i++) idx = idx * 2 + int'((r >> i) & 1);
    return idx;
  endfunction

  function automatic void model(output bit a, output logic [15:0] s);
    bit bc, mc, pm, runt, lng, err, ad, q;
    int n = int'(frame_len);
    bc = (dst_addr == {48{1'b1}});
    mc = dst_addr[40] && !bc;
    pm = (dst_addr == station_addr);
    runt = n < 64; lng = n > 4096;
    err = crc_bad || align_bad || sym_bad;
    ad = (bc && acc_bcast) || (mc && acc_mcast && mc_table[hash_of(dst_addr)])
      || (pm && acc_phys) || (!dst_addr[40] && acc_promisc);
    if (err && !acc_err) q = !acc_runt && (n > (err_short ? 8 : 64));
    else q = !runt || (acc_runt && n >= 8);
    a = ad && q;
    s = 0;
    s[15] = mc; s[14] = pm; s[13] = bc; s[5] = sym_bad; s[4] = runt;
    s[3] = lng; s[2] = crc_bad; s[1] = align_bad;
    s[0] = a && !err && !runt && !lng;
  endfunction

  always @(posedge clk) begin
    bit a; logic [15:0] s;
    model(a, s);
    if (!rst_n || !frame_end) begin e_v <= 0; e_a <= 0; e_s <= 0; end
    else begin e_v <= 1; e_a <= a; e_s <= s; end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (res_valid !== e_v || res_accept !== e_a || res_status !== e_s) begin
      bad++;
      $display("FAIL model R1-R10 cycle: got v=%0b a=%0b s=%h exp v=%0b a=%0b s=%h",
               res_valid, res_accept, res_status, e_v, e_a, e_s);
    end
  end

  task automatic frame(input string tag, input logic [47:0] d, input int n,
                       input bit c, input bit al, input bit sy,
                       input bit xa, input logic [15:0] xs);
    dst_addr = d; frame_len = 14'(n); crc_bad = c; align_bad = al; sym_bad = sy;
    frame_end = 1;
    @(negedge clk);
    frame_end = 0;
    checks++;
    if (res_valid !== 1 || res_accept !== xa || res_status !== xs) begin
      bad++;
      $display("FAIL %s: got v=%0b a=%0b s=%h exp v=1 a=%0b s=%h",
               tag, res_valid, res_accept, res_status, xa, xs);
    end
    @(negedge clk);
    checks++;
    if (res_valid !== 0 || res_accept !== 0 || res_status !== 0) begin
      bad++;
      $display("FAIL R1 after strobe: got v=%0b a=%0b s=%h exp 0 0 0000",
               res_valid, res_accept, res_status);
    end
  endtask

  localparam logic [47:0] BC = '1, OTHER = 48'h00AA_BBCC_DDEE,
                          MC = 48'h0100_5E00_0001;

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (res_valid !== 0 || res_accept !== 0 || res_status !== 0) begin
      bad++;
      $display("FAIL R1 reset: got v=%0b a=%0b s=%h exp 0 0 0000",
               res_valid, res_accept, res_status);
    end
    frame("R2 broadcast", BC, 100, 0,0,0, 1, 16'h2001);
    frame("R4 station", station_addr, 100, 0,0,0, 1, 16'h4001);
    frame("R5 foreign no promisc", OTHER, 100, 0,0,0, 0, 16'h0000);
    acc_promisc = 1;
    frame("R5 foreign promisc", OTHER, 100, 0,0,0, 1, 16'h0001);
    acc_promisc = 0;
    frame("R3 mcast full table", MC, 100, 0,0,0, 1, 16'h8001);
    mc_table = '0;
    frame("R3 mcast empty table", MC, 100, 0,0,0, 0, 16'h8000);
    h = hash_of(MC);
    mc_table = 64'h1 << h;
    frame("R3 mcast single bit", MC, 100, 0,0,0, 1, 16'h8001);
    mc_table = ~(64'h1 << h);
    frame("R3 mcast single hole", MC, 100, 0,0,0, 0, 16'h8000);
    mc_table = '1;
    acc_bcast = 0;
    frame("R2 broadcast off", BC, 100, 0,0,0, 0, 16'h2000);
    acc_bcast = 1;
    frame("R6 runt refused", station_addr, 40, 0,0,0, 0, 16'h4010);
    frame("R6 len 63", station_addr, 63, 0,0,0, 0, 16'h4010);
    frame("R6 len 64", station_addr, 64, 0,0,0, 1, 16'h4001);
    acc_runt = 1;
    frame("R6 runt kept", station_addr, 40, 0,0,0, 1, 16'h4010);
    frame("R6 len 7", station_addr, 7, 0,0,0, 0, 16'h4010);
    frame("R6 len 8", station_addr, 8, 0,0,0, 1, 16'h4010);
    frame("R9 runt-only drops err", station_addr, 100, 1,0,0, 0, 16'h4004);
    acc_runt = 0;
    frame("R7 len 4097", station_addr, 4097, 0,0,0, 1, 16'h4008);
    frame("R7 len 4096", station_addr, 4096, 0,0,0, 1, 16'h4001);
    acc_err = 1;
    frame("R8 crc", station_addr, 100, 1,0,0, 1, 16'h4004);
    frame("R8 align", station_addr, 100, 0,1,0, 1, 16'h4002);
    frame("R8 symbol", station_addr, 100, 0,0,1, 1, 16'h4020);
    acc_err = 0;
    frame("R9 err len 64", station_addr, 64, 1,0,0, 0, 16'h4004);
    frame("R9 err len 65", station_addr, 65, 1,0,0, 1, 16'h4004);
    err_short = 1;
    frame("R9 short err len 8", station_addr, 8, 1,0,0, 0, 16'h4014);
    frame("R9 short err len 9", station_addr, 9, 0,1,0, 1, 16'h4012);
    err_short = 0;
    for (int i = 0; i < 40; i++) begin
      logic [47:0] d;
      d = {$urandom, $urandom} ;
      if (i % 3 == 0) d[40] = 1;
      mc_table = {$urandom, $urandom};
      {acc_err, acc_runt, acc_promisc, err_short} = 4'($urandom);
      dst_addr = d; frame_len = 14'($urandom_range(0, 5000));
      {crc_bad, align_bad, sym_bad} = 3'($urandom) & 3'($urandom);
      frame_end = 1;
      @(negedge clk);
      frame_end = 0;
      @(negedge clk);
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule